// File: doc/BRIEF.md
# Serial GPIO Shift Engine

This block turns four wires into a large bank of general-purpose pins. Up to 32 ports, each 1 to 4 bits wide, are shifted out on a serial data line, one bit per serial clock period. At the same time, the returning serial data line is sampled, so the external shift-register chain drives output pins and reports input pins in the same pass. When a pass ends, a load strobe tells the external chain to latch its outputs and sample its inputs.

Bursts start in one of two ways. In auto-repeat mode, a new burst starts each time a programmable gap ends. In single-shot mode, software sets a request bit that starts one burst straight away. The engine clears that bit when the burst ends, unless auto-repeat is on. Output values come from 3-bit source fields packed in a per-port configuration word. Captured inputs are kept in one word per bit index, with one bit for each port, and all of them update together at the end of the load period.

Top module: `sgpio_engine`

## Requirements
- R1: While rst_n is low at a clock edge, sclk, sdo, sload and shot_pending are 0 and every bit of in_words is 0.
- R2: One serial period lasts max(clk_div, 2) system cycles. sclk is high only during a shifting period, from phase count clk_div/2 (rounded down) to the end of that period, so rising edges inside a burst are exactly one period apart.
- R3: A burst visits the enabled ports (bit p of port_en) in ascending port order and skips disabled ports entirely. Within a port it visits bits 0, 1, ... in ascending order, and it gives exactly one sclk pulse for each visited slot.
- R4: width_m1 holds the number of bits per port minus one, so a burst has popcount(port_en) * (width_m1 + 1) slots. port_en and width_m1 are latched when the burst starts.
- R5: During the slot for port p, bit b, sdo equals out_cfg[(p*4 + b)*3]. This is bit 0 of that bit's 3-bit source field, and the two upper field bits have no effect.
- R6: sdi is sampled while sclk is high in each slot. After the burst, the value for port p, bit b appears at in_words[b*32 + p].
- R7: in_words changes only on the clock edge that ends the load period. Slots not visited by a burst keep their previous captured value.
- R8: After the last slot, sload is high for exactly one serial period, and sclk stays low during that period.
- R9: A pulse on shot_set sets shot_pending, which starts a burst at the next period boundary. shot_pending clears on the edge that ends the load period if auto_repeat is 0. It stays set while auto_repeat is 1.
- R10: With auto_repeat set and no request pending, successive sload rising edges are (slots + 1 + gap_len) serial periods apart. With auto_repeat clear and no request pending, no further bursts start.
- R11: A pending single-shot request skips the gap, so under auto-repeat successive sload rising edges are (slots + 1) periods apart.
- R12: A burst with no enabled port has no sclk pulse, consists only of the load period, leaves in_words unchanged and still clears the single-shot request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| auto_repeat | input | 1 | Repeat bursts after the gap |
| shot_set | input | 1 | One-cycle pulse that requests a single burst |
| width_m1 | input | 2 | Bits per port minus one |
| clk_div | input | 12 | System cycles per serial period (minimum 2) |
| gap_len | input | 8 | Serial periods between repeated bursts |
| port_en | input | 32 | Port participation mask |
| out_cfg | input | 384 | Per-port words of four 3-bit source fields |
| sdi | input | 1 | Serial data returning from the chain |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data to the chain |
| sload | output | 1 | Latch strobe at the end of a burst |
| in_words | output | 128 | Captured inputs, one 32-bit word per bit index |
| shot_pending | output | 1 | Single-shot request bit |

## Verification
shot_pending is set on the edge after the shot_set pulse. The burst starts at the next serial period boundary, so its start delay depends on the phase of the divider. For that reason the bench does not count cycles from the stimulus. It waits for shot_pending to fall and checks in_words in the half-cycle after that edge, since both change on the same edge. A monitor sampling on falling clock edges records sdo at each sclk rising edge, the spacing of those edges, the width of sload and the spacing of sload rising edges. These are compared with counts derived from the requirements: one period of clk_div cycles, sload high for one period, and (slots + 1 + gap) periods between bursts.

// File: rtl/sgpio_pkg.sv
// Shared types for the serial GPIO shift engine.
// Assumes: only one engine state encoding is used across the sub-blocks.
package sgpio_pkg;
    localparam int SRC_FIELD_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LOAD  = 2'd2,
        ST_GAP   = 2'd3
    } sgpio_state_t;
endpackage

// File: rtl/sgpio_clkdiv.sv
// Serial period generator. Counts system cycles within a serial period and
// produces the end-of-period tick, the high-phase flag and the mid-point strobe.
// Assumes: a divider below 2 is treated as 2.
module sgpio_clkdiv #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    output logic             tick,
    output logic             hi_phase,
    output logic             mid
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] half;

    // Clamp the divider and derive the half point.
    always_comb begin
        div_eff = (div < DIV_W'(2)) ? DIV_W'(2) : div;
        half    = div_eff >> 1;
    end

    assign tick     = (cnt >= div_eff - DIV_W'(1));
    assign hi_phase = (cnt >= half);
    assign mid      = (cnt == half);

    // Phase counter, wraps at the end of each serial period.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + DIV_W'(1);
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
endmodule

// File: rtl/sgpio_seq.sv
// Burst sequencer. Walks the enabled ports and their bits once per serial
// period, then one load period, then either idles or waits out the gap.
// Assumes: state advances only on the divider tick.
module sgpio_seq
    import sgpio_pkg::*;
#(
    parameter int NPORTS = 32,
    parameter int BW     = 2,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NPORTS-1:0] port_en,
    input  logic [BW-1:0]     width_m1,
    input  logic              auto_rep,
    input  logic              shot_q,
    input  logic [GAP_W-1:0]  gap_len,
    output sgpio_state_t      st,
    output logic [$clog2(NPORTS)-1:0] port_q,
    output logic [BW-1:0]     bit_q,
    output logic              load_end
);
    localparam int PW = $clog2(NPORTS);

    logic [NPORTS-1:0] en_l;
    logic [BW-1:0]     wm1_l;
    logic [GAP_W-1:0]  gcnt;

    sgpio_state_t      nst;
    logic [PW-1:0]     nport;
    logic [BW-1:0]     nbit;
    logic [GAP_W-1:0]  ngc;
    logic [NPORTS-1:0] nen;
    logic [BW-1:0]     nwm;
    logic              go;
    logic [PW:0]       nxt_hit;
    logic [PW:0]       first_hit;

    // Lowest set bit of m at or above position from; MSB flags a hit.
    function automatic logic [PW:0] find_from(input logic [NPORTS-1:0] m,
                                              input int from);
        logic [PW:0] r;
        r = '0;
        for (int i = NPORTS - 1; i >= 0; i--) begin
            if (m[i] && i >= from) r = {1'b1, PW'(i)};
        end
        return r;
    endfunction

    assign load_end = tick && (st == ST_LOAD);

    // Next-state decision for the burst walk, load and gap.
    always_comb begin
        nst       = st;
        nport     = port_q;
        nbit      = bit_q;
        ngc       = gcnt;
        nen       = en_l;
        nwm       = wm1_l;
        go        = 1'b0;
        nxt_hit   = find_from(en_l, int'(port_q) + 1);
        first_hit = find_from(port_en, 0);
        case (st)
            ST_IDLE:  go = shot_q || auto_rep;
            ST_SHIFT: begin
                if (bit_q < wm1_l) begin
                    nbit = bit_q + BW'(1);
                end else if (nxt_hit[PW]) begin
                    nport = nxt_hit[PW-1:0];
                    nbit  = '0;
                end else begin
                    nst = ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (!auto_rep)                        nst = ST_IDLE;
                else if (shot_q || gap_len == '0)     go  = 1'b1;
                else begin
                    nst = ST_GAP;
                    ngc = '0;
                end
            end
            default: begin
                if (!auto_rep) nst = ST_IDLE;
                else if (shot_q || ((GAP_W+1)'(gcnt) + (GAP_W+1)'(1)) >= (GAP_W+1)'(gap_len))
                    go = 1'b1;
                else ngc = gcnt + GAP_W'(1);
            end
        endcase
        if (go) begin
            nen  = port_en;
            nwm  = width_m1;
            nbit = '0;
            if (first_hit[PW]) begin
                nst   = ST_SHIFT;
                nport = first_hit[PW-1:0];
            end else begin
                nst = ST_LOAD;
            end
        end
    end

    // Sequencer registers, updated once per serial period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            port_q <= '0;
            bit_q  <= '0;
            gcnt   <= '0;
            en_l   <= '0;
            wm1_l  <= '0;
        end else if (tick) begin
            st     <= nst;
            port_q <= nport;
            bit_q  <= nbit;
            gcnt   <= ngc;
            en_l   <= nen;
            wm1_l  <= nwm;
        end
    end

    AST_SLOT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SHIFT) |-> (en_l[port_q] && bit_q <= wm1_l)); // R3
    AST_LOAD_ONE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |=> (st != ST_LOAD)); // R8
endmodule

// File: rtl/sgpio_capture.sv
// Input capture. Samples serial input into a shadow array during the burst and
// copies the shadow to the visible words in one step at the end of the load period.
// Assumes: sample and commit never occur in the same cycle.
module sgpio_capture #(
    parameter int NPORTS  = 32,
    parameter int MAXBITS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample,
    input  logic [$clog2(NPORTS)-1:0]   port_idx,
    input  logic [$clog2(MAXBITS)-1:0]  bit_idx,
    input  logic                        sdi,
    input  logic                        commit,
    output logic [MAXBITS*NPORTS-1:0]   in_words
);
    localparam int TOT = MAXBITS * NPORTS;

    logic [TOT-1:0] shadow;
    int             slot;

    assign slot = int'(bit_idx) * NPORTS + int'(port_idx);

    // Shadow capture of one slot per serial period.
    always_ff @(posedge clk) begin
        if (!rst_n)      shadow       <= '0;
        else if (sample) shadow[slot] <= sdi;
    end

    // Visible words update in a single step on commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      in_words <= '0;
        else if (commit) in_words <= shadow;
    end

    AST_WORDS_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(in_words)); // R7
endmodule

// File: rtl/sgpio_engine.sv
// Serial GPIO shift engine top. Joins divider, sequencer and capture, holds the
// single-shot request bit and selects the serial output bit.
// Assumes: out_cfg holds one word of MAXBITS 3-bit source fields per port.
module sgpio_engine
    import sgpio_pkg::*;
#(
    parameter int NPORTS  = 32,
    parameter int MAXBITS = 4,
    parameter int DIV_W   = 12,
    parameter int GAP_W   = 8
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  auto_repeat,
    input  logic                                  shot_set,
    input  logic [$clog2(MAXBITS)-1:0]            width_m1,
    input  logic [DIV_W-1:0]                      clk_div,
    input  logic [GAP_W-1:0]                      gap_len,
    input  logic [NPORTS-1:0]                     port_en,
    input  logic [NPORTS*MAXBITS*SRC_FIELD_W-1:0] out_cfg,
    input  logic                                  sdi,
    output logic                                  sclk,
    output logic                                  sdo,
    output logic                                  sload,
    output logic [MAXBITS*NPORTS-1:0]             in_words,
    output logic                                  shot_pending
);
    localparam int PW = $clog2(NPORTS);
    localparam int BW = $clog2(MAXBITS);

    logic         tick, hi_phase, mid, load_end, shifting;
    sgpio_state_t st;
    logic [PW-1:0] port_q;
    logic [BW-1:0] bit_q;
    logic          shot_q;
    int            src_pos;

    sgpio_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .div(clk_div),
        .tick(tick), .hi_phase(hi_phase), .mid(mid)
    );

    sgpio_seq #(.NPORTS(NPORTS), .BW(BW), .GAP_W(GAP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .port_en(port_en),
        .width_m1(width_m1), .auto_rep(auto_repeat), .shot_q(shot_q),
        .gap_len(gap_len), .st(st), .port_q(port_q), .bit_q(bit_q),
        .load_end(load_end)
    );

    sgpio_capture #(.NPORTS(NPORTS), .MAXBITS(MAXBITS)) u_cap (
        .clk(clk), .rst_n(rst_n), .sample(shifting && mid),
        .port_idx(port_q), .bit_idx(bit_q), .sdi(sdi),
        .commit(load_end), .in_words(in_words)
    );

    // Serial outputs from sequencer state and divider phase.
    always_comb begin
        shifting = (st == ST_SHIFT);
        src_pos  = (int'(port_q) * MAXBITS + int'(bit_q)) * SRC_FIELD_W;
        sdo      = shifting && out_cfg[src_pos];
        sclk     = shifting && hi_phase;
        sload    = (st == ST_LOAD);
    end

    // Single-shot request: set by software, cleared at burst end without repeat.
    always_ff @(posedge clk) begin
        if (!rst_n)                         shot_q <= 1'b0;
        else if (shot_set)                  shot_q <= 1'b1;
        else if (load_end && !auto_repeat)  shot_q <= 1'b0;
    end

    assign shot_pending = shot_q;

    AST_SHOT_KEPT_IN_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_q && auto_repeat) |=> shot_pending); // R9
    AST_SHOT_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_q && !load_end) |=> shot_pending); // R9
    AST_LOAD_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        sload |-> !sclk); // R8
endmodule

// File: tb/sgpio_engine_tb.sv
module sgpio_engine_tb;
    localparam int NP = 32;
    localparam int MB = 4;
    localparam int NV = 5;

    // {port_en[63:32], width_m1[31:28], div[27:20], inv[19:16], seed[15:0]}
    localparam logic [63:0] VEC [NV] = '{
        {32'hFFFF_FFFF, 4'd3, 8'd2, 4'd0, 16'hA5C3},
        {32'h0000_0001, 4'd0, 8'd3, 4'd1, 16'h1234},
        {32'h8000_0001, 4'd1, 8'd5, 4'd0, 16'hF00F},
        {32'h0F0F_00F0, 4'd2, 8'd4, 4'd1, 16'h5A69},
        {32'h0001_0000, 4'd3, 8'd1, 4'd0, 16'h0FF0}
    };

    logic clk = 0, rst_n = 0;
    logic auto_repeat = 0, shot_set = 0, inv = 0;
    logic [1:0] width_m1 = 0;
    logic [11:0] clk_div = 12'd2;
    logic [7:0] gap_len = 0;
    logic [NP-1:0] port_en = 0;
    logic [NP*MB*3-1:0] out_cfg = 0;
    logic sdi, sclk, sdo, sload, shot_pending;
    logic [MB*NP-1:0] in_words;

    int checks = 0, errors = 0;
    int cyc = 0;
    logic [MB*NP-1:0] exp_in = 0;
    logic exp_seq [128];
    int exp_len;

    // monitor state
    logic prev_sclk = 0, prev_sload = 0;
    logic [MB*NP-1:0] prev_in = 0;
    int cur_len = 0, last_len = 0, last_rise = 0;
    int pmin = 0, pmax = 0, lmin = 0, lmax = 0;
    int load_cyc = 0, prev_load_cyc = 0, nloads = 0, load_w = 0;
    int atomic_viol = 0;
    logic cur_seq [128];
    logic last_seq [128];

    assign sdi = sdo ^ inv;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sgpio_engine u_dut (
        .clk(clk), .rst_n(rst_n), .auto_repeat(auto_repeat), .shot_set(shot_set),
        .width_m1(width_m1), .clk_div(clk_div), .gap_len(gap_len),
        .port_en(port_en), .out_cfg(out_cfg), .sdi(sdi), .sclk(sclk),
        .sdo(sdo), .sload(sload), .in_words(in_words), .shot_pending(shot_pending)
    );

    // Serial monitor sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (sclk && !prev_sclk) begin
                if (cur_len > 0) begin
                    if (pmin == 0 || cyc - last_rise < pmin) pmin = cyc - last_rise;
                    if (cyc - last_rise > pmax) pmax = cyc - last_rise;
                end
                if (cur_len < 128) cur_seq[cur_len] = sdo;
                cur_len++;
                last_rise = cyc;
            end
            if (sload && !prev_sload) begin
                last_len = cur_len;
                for (int i = 0; i < 128; i++) last_seq[i] = cur_seq[i];
                lmin = pmin; lmax = pmax;
                cur_len = 0; pmin = 0; pmax = 0;
                prev_load_cyc = load_cyc;
                load_cyc = cyc;
                nloads++;
            end
            if (!sload && prev_sload) load_w = cyc - load_cyc;
            if (in_words != prev_in && !(prev_sload && !sload)) atomic_viol++;
        end
        prev_sclk = sclk;
        prev_sload = sload;
        prev_in = in_words;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic src_bit(input logic [15:0] seed, input int p, input int b);
        return seed[(p * 3 + b * 5) % 16] ^ p[0];
    endfunction

    task automatic wait_shot_clear();
        for (int i = 0; i < 20000 && shot_pending; i++) @(negedge clk);
    endtask

    task automatic wait_loads(input int n);
        int target;
        target = nloads + n;
        for (int i = 0; i < 20000 && nloads < target; i++) @(negedge clk);
    endtask

    task automatic fire_shot();
        @(negedge clk) shot_set = 1;
        @(negedge clk) shot_set = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int w, dv, mism, slots;
        logic [15:0] seed;
        logic [NP-1:0] en;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(!sclk && !sdo && !sload && !shot_pending, "R1 reset outputs",
              {sclk, sdo, sload, shot_pending}, 0);
        check(in_words == '0, "R1 reset in_words", longint'(in_words[63:0]), 0);
        @(negedge clk) rst_n = 1;

        // Vector table: single-shot bursts under varied shapes.
        for (int v = 0; v < NV; v++) begin
            en = VEC[v][63:32]; w = int'(VEC[v][31:28]);
            dv = int'(VEC[v][27:20]); seed = VEC[v][15:0];
            port_en = en; width_m1 = 2'(w); clk_div = 12'(dv); inv = VEC[v][16];
            for (int p = 0; p < NP; p++)
                for (int b = 0; b < MB; b++) begin
                    logic s;
                    s = src_bit(seed, p, b);
                    out_cfg[(p*MB+b)*3 +: 3] = {~s, ~s, s};
                end
            exp_len = 0;
            for (int p = 0; p < NP; p++)
                if (en[p])
                    for (int b = 0; b <= w; b++) begin
                        exp_seq[exp_len] = src_bit(seed, p, b);
                        exp_len++;
                        exp_in[b*NP + p] = src_bit(seed, p, b) ^ inv;
                    end
            fire_shot();
            wait_shot_clear();
            @(negedge clk);
            if (dv < 2) dv = 2;
            check(!shot_pending, "R9 shot cleared", shot_pending, 0);
            check(last_len == exp_len, "R3 R4 slot count", last_len, exp_len);
            mism = 0;
            for (int i = 0; i < exp_len; i++) if (last_seq[i] !== exp_seq[i]) mism++;
            check(mism == 0, "R3 R5 serial order/value", mism, 0);
            check(in_words == exp_in, "R6 R7 captured words",
                  longint'(in_words[63:0] ^ exp_in[63:0]) + longint'(in_words[127:64] ^ exp_in[127:64]), 0);
            if (exp_len > 1)
                check(lmin == dv && lmax == dv, "R2 serial period", lmax, dv);
            check(load_w == dv, "R8 load width", load_w, dv);
        end

        // R12: no enabled ports.
        port_en = '0; clk_div = 12'd3;
        fire_shot();
        wait_shot_clear();
        @(negedge clk);
        check(last_len == 0, "R12 no pulses", last_len, 0);
        check(in_words == exp_in, "R12 words unchanged", longint'(in_words[31:0]), longint'(exp_in[31:0]));
        check(!shot_pending, "R12 shot cleared", shot_pending, 0);

        // R10: auto-repeat interval.
        port_en = 32'h3; width_m1 = 2'd0; clk_div = 12'd3; gap_len = 8'd4;
        auto_repeat = 1;
        wait_loads(3);
        slots = 2;
        check(load_cyc - prev_load_cyc == (slots + 1 + 4) * 3, "R10 repeat interval",
              load_cyc - prev_load_cyc, (slots + 1 + 4) * 3);

        // R11: pending shot preempts the gap; R9 bit kept under repeat.
        fire_shot();
        wait_loads(3);
        check(load_cyc - prev_load_cyc == (slots + 1) * 3, "R11 preempt interval",
              load_cyc - prev_load_cyc, (slots + 1) * 3);
        check(shot_pending, "R9 kept in repeat", shot_pending, 1);

        // R9/R10: repeat off, request clears, bursts stop.
        auto_repeat = 0;
        wait_shot_clear();
        @(negedge clk);
        check(!shot_pending, "R9 cleared after repeat off", shot_pending, 0);
        begin
            int n0;
            n0 = nloads;
            repeat (100) @(negedge clk);
            check(nloads == n0, "R10 no bursts when idle", nloads - n0, 0);
        end

        check(atomic_viol == 0, "R7 words change only at load end", atomic_viol, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule